// File: doc/BRIEF.md
# Serial CRC Generator and Checker

This block sits beside a byte-oriented serial shift engine and keeps two CRC calculators, one over the bits the engine sends and one over the bits it receives. Both advance one bit per sampling strobe through a Galois shift with a programmable polynomial. The bits reach the calculators in whatever order the engine shifts them, so MSB-first and LSB-first framing are both supported.

When software requests it, the block turns the next byte slot into a CRC slot. It waits for the byte in flight to finish and for any byte still queued in the transmit buffer. During that slot it offers the transmit CRC for serialization, and both calculators hold their values. It collects the incoming byte and, when the slot ends, compares that byte with the held receive CRC. A mismatch sets a sticky error flag.

Top module: `spi_crc_unit`

## Requirements
- R1: After reset, `tx_crc`, `rx_crc`, `crc_phase`, `crc_next` and `crc_err` are all zero.
- R2: While `crc_en` is high and `crc_phase` is low, each cycle with `bit_stb` high updates each calculator as follows: `fb = crc[W-1] ^ bit`, then `crc = (crc << 1) ^ (fb ? poly : 0)`. The transmit calculator takes `tx_bit` and the receive calculator takes `rx_bit`. Cycles without `bit_stb` leave both values unchanged.
- R3: While `crc_en` is low, both calculators, `crc_phase` and `crc_next` are held at zero, so enabling the block always starts from a cleared state.
- R4: A pulse on `crc_next_set` sets `crc_next`. A `byte_done` pulse ends a data byte. If it arrives while `crc_next` is high and `tx_pending` is low, `crc_phase` is high from the next cycle, and `crc_out` then equals `tx_crc`.
- R5: If `tx_pending` is high at a data byte's `byte_done`, the CRC slot does not start. It starts after the following byte.
- R6: While `crc_phase` is high, neither calculator changes, whatever the strobes and bits.
- R7: During the CRC slot, the `rx_bit` values are assembled into a byte. In MSB-first mode (`lsb_first`=0) the first bit becomes bit W-1. In LSB-first mode the first bit becomes bit 0. At the slot's `byte_done`, a byte that differs from `rx_crc` sets `crc_err`, and `crc_phase` falls in the next cycle.
- R8: `crc_next` clears at the end of the CRC slot.
- R9: `crc_err` stays set until an `err_clr` pulse clears it. A new mismatch in the same cycle as `err_clr` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| crc_en | input | 1 | CRC enable; low clears the calculators |
| poly | input | W | Generator polynomial |
| lsb_first | input | 1 | Shift order of the engine |
| bit_stb | input | 1 | One pulse per sampled bit |
| tx_bit | input | 1 | Transmitted bit |
| rx_bit | input | 1 | Received bit |
| byte_done | input | 1 | Pulses with the last bit strobe of a byte |
| tx_pending | input | 1 | A byte is waiting in the transmit buffer |
| crc_next_set | input | 1 | Request a CRC slot after the pending data |
| err_clr | input | 1 | Clears the CRC error flag |
| crc_out | output | W | CRC byte to serialize |
| crc_phase | output | 1 | The current byte slot carries the CRC |
| crc_next | output | 1 | A CRC slot is requested |
| crc_err | output | 1 | Received CRC mismatch (sticky) |
| tx_crc | output | W | Transmit calculator value |
| rx_crc | output | W | Receive calculator value |

## Verification
The assertions check the following on every cycle:
- both calculators stay cleared while the block is disabled;
- both calculators hold still throughout the CRC slot;
- the slot only begins on a byte boundary with a request and an empty transmit buffer;
- the request clears when the slot ends;
- the error flag is sticky and clears on a clear strobe.

Only the bench's scenarios can show the rest:
- the polynomial arithmetic over random data;
- the deferral behind a queued byte;
- the bit assembly in both shift orders;
- that a corrupted CRC byte, and only a corrupted one, raises the error.

// File: rtl/spi_crc_unit.sv
module spi_crc_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         crc_en,
  input  logic [W-1:0] poly,
  input  logic         lsb_first,
  input  logic         bit_stb,
  input  logic         tx_bit,
  input  logic         rx_bit,
  input  logic         byte_done,
  input  logic         tx_pending,
  input  logic         crc_next_set,
  input  logic         err_clr,
  output logic [W-1:0] crc_out,
  output logic         crc_phase,
  output logic         crc_next,
  output logic         crc_err,
  output logic [W-1:0] tx_crc,
  output logic [W-1:0] rx_crc
);

  function automatic logic [W-1:0] crc_step(logic [W-1:0] r, logic b, logic [W-1:0] p);
    logic fb;
    fb = r[W-1] ^ b;
    return {r[W-2:0], 1'b0} ^ (fb ? p : '0);
  endfunction

  logic [W-1:0] tx_q, rx_q, sh_q;
  logic         phase_q, next_q, err_q;

  wire [W-1:0] sh_d      = lsb_first ? {rx_bit, sh_q[W-1:1]} : {sh_q[W-2:0], rx_bit};
  wire         upd       = bit_stb && !phase_q;
  wire         phase_go  = byte_done && !phase_q && next_q && !tx_pending;
  wire         phase_end = byte_done && phase_q;
  wire         mismatch  = crc_en && phase_end && (sh_d != rx_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q    <= '0;
      rx_q    <= '0;
      sh_q    <= '0;
      phase_q <= 1'b0;
      next_q  <= 1'b0;
    end else if (!crc_en) begin
      tx_q    <= '0;
      rx_q    <= '0;
      phase_q <= 1'b0;
      next_q  <= 1'b0;
    end else begin
      if (upd) begin
        tx_q <= crc_step(tx_q, tx_bit, poly);
        rx_q <= crc_step(rx_q, rx_bit, poly);
      end
      if (phase_q && bit_stb) sh_q <= sh_d;
      if (phase_go) phase_q <= 1'b1;
      if (phase_end) begin
        phase_q <= 1'b0;
        next_q  <= 1'b0;
      end else if (crc_next_set) begin
        next_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        err_q <= 1'b0;
    else if (mismatch) err_q <= 1'b1;
    else if (err_clr)  err_q <= 1'b0;
  end

  assign crc_out   = tx_q;
  assign tx_crc    = tx_q;
  assign rx_crc    = rx_q;
  assign crc_phase = phase_q;
  assign crc_next  = next_q;
  assign crc_err   = err_q;

endmodule

// File: rtl/spi_crc_unit_chk.sv
module spi_crc_unit_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         crc_en,
  input logic         byte_done,
  input logic         tx_pending,
  input logic         err_clr,
  input logic         crc_phase,
  input logic         crc_next,
  input logic         crc_err,
  input logic [W-1:0] tx_crc,
  input logic [W-1:0] rx_crc
);

  p_disabled_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !crc_en |=> (tx_crc == '0 && rx_crc == '0 && !crc_phase && !crc_next));

  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_phase && crc_en) |=> ($stable(tx_crc) && $stable(rx_crc)));

  p_phase_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!crc_phase && crc_en && !(byte_done && crc_next && !tx_pending)) |=> !crc_phase);

  p_next_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_phase && byte_done) |=> !crc_next);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_err && !err_clr) |=> crc_err);

  p_err_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !crc_phase) |=> !crc_err);

endmodule

bind spi_crc_unit spi_crc_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .crc_en(crc_en), .byte_done(byte_done),
  .tx_pending(tx_pending), .err_clr(err_clr), .crc_phase(crc_phase),
  .crc_next(crc_next), .crc_err(crc_err), .tx_crc(tx_crc), .rx_crc(rx_crc)
);

// File: tb/spi_crc_unit_tb.sv
module spi_crc_unit_tb;
  localparam int W = 8;

  logic clk = 0, rst_n = 0;
  logic crc_en = 0, lsb_first = 0, bit_stb = 0, tx_bit = 0, rx_bit = 0;
  logic byte_done = 0, tx_pending = 0, crc_next_set = 0, err_clr = 0;
  logic [W-1:0] poly = 8'h07;
  logic [W-1:0] crc_out, tx_crc, rx_crc;
  logic crc_phase, crc_next, crc_err;

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] m_tx, m_rx;
  logic m_phase, m_next, m_err;
  bit done = 0;

  always #10ns clk = ~clk;

  spi_crc_unit #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .crc_en(crc_en), .poly(poly), .lsb_first(lsb_first),
    .bit_stb(bit_stb), .tx_bit(tx_bit), .rx_bit(rx_bit), .byte_done(byte_done),
    .tx_pending(tx_pending), .crc_next_set(crc_next_set), .err_clr(err_clr),
    .crc_out(crc_out), .crc_phase(crc_phase), .crc_next(crc_next), .crc_err(crc_err),
    .tx_crc(tx_crc), .rx_crc(rx_crc)
  );

  function automatic logic [W-1:0] ref_step(logic [W-1:0] r, logic b, logic [W-1:0] p);
    logic [W-1:0] s;
    s = r << 1;
    if (r[W-1] != b) s = s ^ p;
    return s;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_regs(input string tag);
    chk(tx_crc == m_tx, {tag, " tx_crc"}, tx_crc, m_tx);
    chk(rx_crc == m_rx, {tag, " rx_crc"}, rx_crc, m_rx);
    chk(crc_phase == m_phase, {tag, " crc_phase"}, crc_phase, m_phase);
    chk(crc_next == m_next, {tag, " crc_next"}, crc_next, m_next);
    chk(crc_err == m_err, {tag, " crc_err"}, crc_err, m_err);
  endtask

  task automatic send_byte(input logic [W-1:0] tb, input logic [W-1:0] rb, input logic pend);
    for (int i = 0; i < W; i++) begin
      int idx;
      idx = lsb_first ? i : W-1-i;
      bit_stb = 1; tx_bit = tb[idx]; rx_bit = rb[idx];
      byte_done = (i == W-1); tx_pending = pend;
      if (!m_phase) begin
        m_tx = ref_step(m_tx, tb[idx], poly);
        m_rx = ref_step(m_rx, rb[idx], poly);
      end
      @(negedge clk);
      bit_stb = 0; byte_done = 0; tx_pending = 0;
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end
    if (m_phase) begin
      if (rb != m_rx) m_err = 1;
      m_phase = 0; m_next = 0;
    end else if (m_next && !pend) m_phase = 1;
  endtask

  task automatic pulse_next();
    crc_next_set = 1; @(negedge clk); crc_next_set = 0; m_next = 1;
  endtask

  task automatic pulse_clr();
    err_clr = 1; @(negedge clk); err_clr = 0; m_err = 0;
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    m_tx = 0; m_rx = 0; m_phase = 0; m_next = 0; m_err = 0;
    repeat (3) @(negedge clk);
    check_regs("R1 reset");
    rst_n = 1;
    @(negedge clk);
    for (int t = 0; t < 40; t++) begin
      logic [W-1:0] cb, rcv, s_tx, s_rx;
      int nb;
      bit defer, bad;
      crc_en = 0; @(negedge clk);
      m_tx = 0; m_rx = 0; m_phase = 0; m_next = 0;
      check_regs("R3 disabled");
      poly = $urandom; poly[0] = 1;
      lsb_first = $urandom_range(0, 1);
      crc_en = 1; @(negedge clk);
      nb = $urandom_range(1, 4);
      defer = (t % 4 == 1);
      bad = (t % 3 == 0);
      for (int b = 0; b < nb; b++) begin
        if (b == nb-1) pulse_next();
        send_byte($urandom, $urandom, (b == nb-1) && defer);
        check_regs("R2 data byte");
      end
      if (defer) begin
        chk(crc_phase == 0, "R5 deferred", crc_phase, 0);
        send_byte($urandom, $urandom, 0);
        check_regs("R5 after queued byte");
      end
      repeat (2) @(negedge clk);
      check_regs("R2 idle hold");
      chk(crc_phase == 1, "R4 slot start", crc_phase, 1);
      chk(crc_out == m_tx, "R4 crc_out", crc_out, m_tx);
      cb = crc_out;
      s_tx = m_tx; s_rx = m_rx;
      rcv = bad ? (m_rx ^ (8'h1 << $urandom_range(0, W-1))) : m_rx;
      send_byte(cb, rcv, $urandom_range(0, 1));
      chk(tx_crc == s_tx && rx_crc == s_rx, "R6 frozen", {tx_crc, rx_crc}, {s_tx, s_rx});
      chk(crc_err == bad, "R7 compare", crc_err, bad);
      chk(crc_phase == 0, "R7 slot end", crc_phase, 0);
      chk(crc_next == 0, "R8 next cleared", crc_next, 0);
      check_regs("R7 after slot");
      if (crc_err) begin
        repeat (3) @(negedge clk);
        chk(crc_err == 1, "R9 sticky", crc_err, 1);
        pulse_clr();
        chk(crc_err == 0, "R9 cleared", crc_err, 0);
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule